// File: doc/BRIEF.md
# External DMA Request Sampler

This block is the request front end of one DMA channel that is paced by an external device. It watches an active-low request line and decides on which cycles that line is looked at. Each accepted request becomes one transfer. The block acknowledges each transfer and issues start strobes to a simple bus sequencer whose read and write cycles each last `BUS_LEN` clocks.

Software loads a transfer count and the configuration with a one-cycle `start` pulse. The configuration selects four things: level or falling-edge request detection, cycle-steal or burst pacing, a dual-address transfer (a read cycle followed by a write cycle) or a single-address transfer (one bus cycle), and whether the transfer acknowledge is placed on the read cycle or on the write cycle. The channel stays busy until every transfer has finished. It then pulses `done`. `BUS_LEN` must lie between 1 and 4, so that the next transfer can never start before the current one has ended.

Top module: `dreq_sampler`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `busy`, `done`, `drak`, `dack`, `rd_go`, `wr_go` and `one_go` are all 0.
- R2: A `start` pulse with a nonzero `count` in a cycle where `busy` is 0 sets `busy` in the next cycle and latches `count` and all `cfg_*` inputs. A `start` pulse with a `count` of 0, or one given while `busy` is 1, has no effect. Sampling begins in the cycle after the start is accepted.
- R3: With level detection (`cfg_edge`=0), a request is seen in any sampling cycle in which `dreq_n` is 0. The first bus cycle of the resulting transfer begins 4 cycles after that sampling cycle.
- R4: With edge detection (`cfg_edge`=1), a request is seen only when `dreq_n` is 1 in one cycle and 0 in the next, which is a sampling cycle. The transfer begins 5 cycles after that sampling cycle. Holding `dreq_n` low does not start another transfer.
- R5: With dual addressing and level detection, the next sampling cycle comes one cycle after the write cycle of the current transfer begins, that is, at transfer start + `BUS_LEN` + 1.
- R6: With dual addressing and edge detection, the next sampling cycle is the last cycle of the current transfer's read cycle, that is, at transfer start + `BUS_LEN` − 1.
- R7: With single addressing, in either detection mode, the next sampling cycle is the cycle after `drak` is asserted for the current transfer.
- R8: From its first sampling cycle onward, the block samples on every cycle until it sees a request. It stops sampling once the transfer count is used up.
- R9: A dual-address transfer consists of a read cycle of `BUS_LEN` clocks, with `rd_go` high in its first clock, followed by a write cycle of `BUS_LEN` clocks, with `wr_go` high in its first clock. A single-address transfer is one cycle of `BUS_LEN` clocks, with `one_go` high in its first clock. `drak` is high for exactly the first clock of every transfer.
- R10: `dack` is high for the whole of every single-address transfer. In a dual-address transfer, `dack` is high during the write cycle when `cfg_ack_wr`=1 and during the read cycle when `cfg_ack_wr`=0.
- R11: Burst mode with edge detection runs every remaining transfer back to back after one detected edge, and does no further sampling. Burst mode with level detection behaves exactly like cycle-steal mode.
- R12: In the cycle after the final clock of the last transfer, `busy` drops to 0 and `done` is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load count and configuration |
| count | input | CNT_W | Number of transfers |
| cfg_edge | input | 1 | 1: falling-edge detection, 0: level detection |
| cfg_burst | input | 1 | 1: burst pacing, 0: cycle steal |
| cfg_single | input | 1 | 1: single-address transfers, 0: dual-address |
| cfg_ack_wr | input | 1 | Dual address: 1 puts `dack` on the write cycle, 0 on the read cycle |
| dreq_n | input | 1 | External request, active low |
| busy | output | 1 | Channel has transfers outstanding |
| done | output | 1 | One-cycle completion pulse |
| drak | output | 1 | Request acknowledge, first clock of each transfer |
| dack | output | 1 | Transfer acknowledge |
| rd_go | output | 1 | Start strobe for a read cycle |
| wr_go | output | 1 | Start strobe for a write cycle |
| one_go | output | 1 | Start strobe for a single-address cycle |

## Verification
Every result is due a fixed number of cycles after its cause. `busy` follows an accepted start by one cycle. A transfer's first strobe follows its sampling cycle by 4 cycles with level detection and 5 with edge detection. The next sampling cycle sits at a fixed offset from the transfer start that depends on the mode, and `done` follows the last transfer clock by one cycle. The bench model turns each detected request into absolute cycle numbers for the transfer starts, the next sampling point and the completion. Every output is then compared against those numbers once per clock, at the falling edge, after all registers have settled.

// File: rtl/dreq_sampler.sv
module dreq_sampler #(
  parameter int CNT_W   = 8,
  parameter int BUS_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             cfg_edge,
  input  logic             cfg_burst,
  input  logic             cfg_single,
  input  logic             cfg_ack_wr,
  input  logic             dreq_n,
  output logic             busy,
  output logic             done,
  output logic             drak,
  output logic             dack,
  output logic             rd_go,
  output logic             wr_go,
  output logic             one_go
);
  localparam int BW = (BUS_LEN > 1) ? $clog2(BUS_LEN) : 1;
  localparam logic [BW-1:0] BC_LAST = BW'(BUS_LEN - 1);
  localparam logic [3:0] OFF_DL = 4'(BUS_LEN + 1);
  localparam logic [3:0] OFF_DE = 4'(BUS_LEN - 1);
  localparam logic [3:0] OFF_SA = 4'd1;

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR, PH_ONE} ph_t;

  logic             busy_q, done_q;
  logic             edge_m, burst_m, single_m, ackwr_m;
  logic [CNT_W-1:0] left;
  logic             dreq_q, samp_en;
  logic [2:0]       lat;
  ph_t              ph;
  logic [BW-1:0]    bc;
  logic [3:0]       age;
  logic             age_run;

  logic       burst_edge, arm_now, hit, xfer_end, launch;
  logic [3:0] off;

  assign burst_edge = burst_m & edge_m;
  assign off        = single_m ? OFF_SA : (edge_m ? OFF_DE : OFF_DL);
  assign arm_now    = age_run && (age == off);
  assign hit        = busy_q && (samp_en || arm_now) && (left != '0) &&
                      (edge_m ? (dreq_q && !dreq_n) : !dreq_n);
  assign xfer_end   = (ph == PH_WR || ph == PH_ONE) && (bc == BC_LAST);
  assign launch     = (lat == 3'd1) || (xfer_end && burst_edge && left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      edge_m   <= 1'b0;
      burst_m  <= 1'b0;
      single_m <= 1'b0;
      ackwr_m  <= 1'b0;
      left     <= '0;
      dreq_q   <= 1'b1;
      samp_en  <= 1'b0;
      lat      <= '0;
      ph       <= PH_IDLE;
      bc       <= '0;
      age      <= '0;
      age_run  <= 1'b0;
    end else begin
      dreq_q <= dreq_n;
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start && count != '0) begin
          busy_q   <= 1'b1;
          edge_m   <= cfg_edge;
          burst_m  <= cfg_burst;
          single_m <= cfg_single;
          ackwr_m  <= cfg_ack_wr;
          left     <= count;
          samp_en  <= 1'b1;
        end
      end else begin
        if (hit) begin
          samp_en <= 1'b0;
          lat     <= edge_m ? 3'd4 : 3'd3;
          left    <= left - 1'b1;
        end else begin
          if (arm_now) samp_en <= 1'b1;
          if (lat != '0) lat <= lat - 3'd1;
        end
        if (launch) begin
          ph      <= single_m ? PH_ONE : PH_RD;
          bc      <= '0;
          age     <= '0;
          age_run <= !burst_edge && (left != '0);
          if (lat != 3'd1) left <= left - 1'b1;
        end else begin
          if (age_run) begin
            if (arm_now) age_run <= 1'b0;
            else         age <= age + 4'd1;
          end
          if (ph != PH_IDLE) begin
            if (bc == BC_LAST) begin
              ph <= (ph == PH_RD) ? PH_WR : PH_IDLE;
              bc <= '0;
            end else begin
              bc <= bc + 1'b1;
            end
          end
        end
        if (xfer_end && !launch && left == '0 && lat == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign rd_go  = (ph == PH_RD)  && (bc == '0);
  assign wr_go  = (ph == PH_WR)  && (bc == '0);
  assign one_go = (ph == PH_ONE) && (bc == '0);
  assign drak   = rd_go | one_go;
  assign dack   = (ph == PH_ONE) || (ph == PH_RD && !ackwr_m) || (ph == PH_WR && ackwr_m);
endmodule

// File: rtl/dreq_sampler_chk.sv
module dreq_sampler_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic drak,
  input logic dack,
  input logic rd_go,
  input logic wr_go,
  input logic one_go
);
  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_go, wr_go, one_go}));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R12
  done_fall_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (dack || drak) |-> busy);
endmodule

bind dreq_sampler dreq_sampler_chk u_chk (.*);

// File: tb/dreq_sampler_tb.sv
module dreq_sampler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 2;
  localparam int CW = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] count = '0;
  logic cfg_edge = 0, cfg_burst = 0, cfg_single = 0, cfg_ack_wr = 0;
  logic dreq_n = 1'b1;
  logic busy, done, drak, dack, rd_go, wr_go, one_go;

  dreq_sampler #(.CNT_W(CW), .BUS_LEN(L)) u_dut (
    .clk(clk), .rst(rst), .start(start), .count(count),
    .cfg_edge(cfg_edge), .cfg_burst(cfg_burst), .cfg_single(cfg_single),
    .cfg_ack_wr(cfg_ack_wr), .dreq_n(dreq_n), .busy(busy), .done(done),
    .drak(drak), .dack(dack), .rd_go(rd_go), .wr_go(wr_go), .one_go(one_go));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  string tag = "R1";

  int c = 0, left = 0, arm_at = 0, done_at = -1;
  bit mbusy = 0, mdone = 0, armed = 0, prev = 1;
  bit e_edge, e_burst, e_single, e_ackwr;
  int starts[$];

  task automatic model_step();
    bit nb = mbusy;
    if (start && !mbusy && count != 0) begin
      nb = 1; e_edge = cfg_edge; e_burst = cfg_burst; e_single = cfg_single;
      e_ackwr = cfg_ack_wr; left = count; armed = 1; arm_at = c + 1;
      done_at = -1; starts.delete();
    end else if (mbusy && armed && c >= arm_at) begin
      bit h = e_edge ? (prev && !dreq_n) : !dreq_n;
      if (h) begin
        int s  = c + (e_edge ? 5 : 4);
        int tl = e_single ? L : 2 * L;
        int of = e_single ? 1 : (e_edge ? L - 1 : L + 1);
        armed = 0;
        if (e_burst && e_edge) begin
          for (int k = 0; k < left; k++) starts.push_back(s + k * tl);
          done_at = s + left * tl;
          left = 0;
        end else begin
          starts.push_back(s);
          left--;
          if (left > 0) begin armed = 1; arm_at = s + of; end
          else done_at = s + tl;
        end
      end
    end
    prev = dreq_n;
    c++;
    mbusy = nb;
    mdone = 0;
    if (mbusy && done_at == c) begin mbusy = 0; mdone = 1; end
  endtask

  function automatic logic [6:0] expected();
    logic [6:0] v = {mbusy, mdone, 5'b0};
    foreach (starts[i]) begin
      int o = c - starts[i];
      if (o >= 0 && o < (e_single ? L : 2 * L)) begin
        v[4] = (o == 0);
        if (e_single) begin v[3] = 1; v[0] = (o == 0); end
        else begin
          v[3] = e_ackwr ? (o >= L) : (o < L);
          v[2] = (o == 0);
          v[1] = (o == L);
        end
      end
    end
    return v;
  endfunction

  task automatic compare();
    logic [6:0] act = {busy, done, drak, dack, rd_go, wr_go, one_go};
    logic [6:0] exp = expected();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: {busy,done,drak,dack,rd,wr,one} got %b expected %b",
               tag, c, act, exp);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  function automatic logic pat(int p, int i);
    case (p)
      0: return 1'b0;
      1: return (i % 7) >= 3;
      2: return i < 2;
      default: return (i % 5) == 0;
    endcase
  endfunction

  task automatic run_case(string t, bit e, bit b, bit s, bit a, int n, int p, int len, int again);
    tag = t;
    cfg_edge = e; cfg_burst = b; cfg_single = s; cfg_ack_wr = a;
    count = CW'(n); start = 1; tick(); start = 0;
    for (int i = 0; i < len; i++) begin
      dreq_n = pat(p, i);
      start = (i == again);
      count = 8'd9;
      tick();
    end
    start = 0;
    for (int k = 0; k < 400 && mbusy; k++) begin
      dreq_n = k[0];
      tick();
    end
    dreq_n = 1;
    repeat (4) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    compare();
    rst = 0;
    tick();
    run_case("R3 R5 R9 R10 R12 level dual ack-read", 0, 0, 0, 0, 3, 0, 40, -1);
    run_case("R4 R6 R8 R10 edge dual ack-write held-low", 1, 0, 0, 1, 3, 2, 40, -1);
    run_case("R3 R7 R8 R9 level single gapped", 0, 0, 1, 0, 3, 1, 40, -1);
    run_case("R4 R7 R8 edge single pulses", 1, 0, 1, 0, 3, 3, 40, -1);
    run_case("R11 burst edge dual", 1, 1, 0, 1, 3, 2, 40, -1);
    run_case("R11 R5 burst level dual", 0, 1, 0, 0, 2, 0, 30, -1);
    run_case("R2 start while busy ignored", 0, 0, 0, 0, 2, 1, 30, 5);
    run_case("R2 zero count ignored", 0, 0, 0, 0, 0, 0, 8, -1);
    checks++;
    if (busy !== 1'b0) begin
      errors++;
      $display("FAIL R2 zero count: busy got %b expected 0", busy);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog: run did not finish, got hung expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule